// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates among five maskable interrupt sources: two external request flags, two timer overflow flags and one serial source. The serial source is the OR of a receive flag and a transmit flag. On an instruction boundary it picks the winning source, raises a one-cycle request towards the CPU, and presents that source's fixed vector address and index. It also sends a one-cycle acknowledge pulse back to the chosen source.

Software controls the block through an enable register and a priority register. The enable register has a master bit and one mask bit per source. The priority register puts each source into either the high group or the low group. The block tracks two nested service levels, one low and one high. A high-group request may interrupt a low-level service. Nothing interrupts a high-level service. The block never checks who set a pending flag, so a flag written by software triggers an interrupt exactly as a flag set by hardware does.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_req`, `src_ack`, `irq_src` and `irq_vector` are all zero, and both service levels are idle.
- R2: While `en_reg[7]` is 0, no request is taken, whatever the other enable bits hold.
- R3: Bits 0..4 of `en_reg` and of `pri_reg` belong to sources 0..4: external 0, timer 0, external 1, timer 1 and serial. A source whose enable bit is 0 is never taken.
- R4: The serial source (index 4) is pending when `ser_rx` or `ser_tx` is high.
- R5: The vector of source index i is 8*i+3 (0x0003, 0x000B, 0x0013, 0x001B, 0x0023), and `irq_src` is i.
- R6: Within one priority group, the pending source with the lowest index wins.
- R7: An eligible high-group source (priority bit 1) wins over any low-group source.
- R8: While only a low-level service is active, a high-group request is taken and a low-group request is not.
- R9: While a high-level service is active, no request is taken.
- R10: A request is taken only in a cycle where `insn_done` is 1 and `reti` is 0.
- R11: `reti` ends the high-level service if one is active, and otherwise ends the low-level service.
- R12: A take shows up one clock later as a single-cycle `irq_req` together with a single-cycle one-hot `src_ack` whose set bit is the index in `irq_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0 | input | 1 | External 0 pending flag |
| tmr0 | input | 1 | Timer 0 overflow flag |
| ext1 | input | 1 | External 1 pending flag |
| tmr1 | input | 1 | Timer 1 overflow flag |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| en_reg | input | 8 | Bit 7 is the master enable; bits 4..0 are the per-source masks |
| pri_reg | input | 5 | Per-source priority; 1 puts the source in the high group |
| insn_done | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | One-cycle request to vector |
| irq_vector | output | 16 | Vector address of the last taken source |
| irq_src | output | 3 | Index of the last taken source |
| src_ack | output | 5 | One-cycle acknowledge, one bit per source |

## Verification
On every cycle, the assertions check the master-enable gate, the instruction-boundary gate and the return-strobe gate. They also check that the acknowledge is one-hot and matches the request, that the vector agrees with the index, and that nothing is taken during a high-level service. Some behaviours can only be shown by the bench scenarios driving the reference model: the polling order within a group, high winning over low, a high request preempting a low service while a second low request waits, and the order in which `reti` unwinds the two levels.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext0,
  input  logic             tmr0,
  input  logic             ext1,
  input  logic             tmr1,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic [7:0]       en_reg,
  input  logic [4:0]       pri_reg,
  input  logic             insn_done,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  output logic [2:0]       irq_src,
  output logic [4:0]       src_ack
);
  localparam int NSRC = 5;

  logic [NSRC-1:0] pend, elig, hi_c, lo_c, pick, first;
  logic [2:0]      idx;
  logic            take, ins_hi, ins_lo;
  logic            unused_en;

  assign unused_en = ^en_reg[6:5];
  assign pend  = {ser_rx | ser_tx, tmr1, ext1, tmr0, ext0};
  assign elig  = pend & en_reg[NSRC-1:0] & {NSRC{en_reg[7]}};
  assign hi_c  = ins_hi ? '0 : (elig & pri_reg);
  assign lo_c  = (ins_hi | ins_lo) ? '0 : (elig & ~pri_reg);
  assign pick  = (|hi_c) ? hi_c : lo_c;
  assign first = pick & (~pick + 1'b1);
  assign take  = insn_done & ~reti & (|pick);

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (first[i]) idx = 3'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      src_ack    <= '0;
      irq_src    <= '0;
      irq_vector <= '0;
      ins_hi     <= 1'b0;
      ins_lo     <= 1'b0;
    end else begin
      irq_req <= take;
      src_ack <= take ? first : '0;
      if (take) begin
        irq_src    <= idx;
        irq_vector <= VEC_W'({idx, 3'b011});
        if (|hi_c) ins_hi <= 1'b1;
        else       ins_lo <= 1'b1;
      end else if (reti) begin
        if (ins_hi) ins_hi <= 1'b0;
        else        ins_lo <= 1'b0;
      end
    end
  end
endmodule

module irq_arbiter_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       en_reg,
  input logic             insn_done,
  input logic             reti,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vector,
  input logic [2:0]       irq_src,
  input logic [4:0]       src_ack,
  input logic             ins_hi
);
  a_r2_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_reg[7] |=> !irq_req);
  a_r10_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_done || reti) |=> !irq_req);
  a_r9_hi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |=> !irq_req);
  a_r12_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack) && (irq_req == (src_ack != 5'd0)));
  a_r12_ack_idx: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> src_ack[irq_src]);
  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector == VEC_W'({irq_src, 3'b011})));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .insn_done(insn_done),
  .reti(reti), .irq_req(irq_req), .irq_vector(irq_vector),
  .irq_src(irq_src), .src_ack(src_ack), .ins_hi(ins_hi));

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic clk = 0, rst_n = 0;
  logic ext0 = 0, tmr0 = 0, ext1 = 0, tmr1 = 0, ser_rx = 0, ser_tx = 0;
  logic [7:0] en_reg = 0;
  logic [4:0] pri_reg = 0;
  logic insn_done = 0, reti = 0;
  logic irq_req;
  logic [15:0] irq_vector;
  logic [2:0] irq_src;
  logic [4:0] src_ack;

  int total = 0, bad = 0, ncyc = 0;
  string cur = "R1";

  int m_hi = 0, m_lo = 0, e_req = 0, e_vec = 0, e_src = 0, e_ack = 0;

  always #10 clk = ~clk;

  irq_arbiter u_dut (.clk, .rst_n, .ext0, .tmr0, .ext1, .tmr1, .ser_rx, .ser_tx,
    .en_reg, .pri_reg, .insn_done, .reti, .irq_req, .irq_vector, .irq_src, .src_ack);

  always @(posedge clk) begin
    int p[5];
    int win;
    int win_hi;
    ncyc++;
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; e_req = 0; e_vec = 0; e_src = 0; e_ack = 0;
    end else begin
      p[0] = ext0; p[1] = tmr0; p[2] = ext1; p[3] = tmr1; p[4] = ser_rx || ser_tx;
      win = -1; win_hi = 0;
      if (en_reg[7] && insn_done && !reti) begin
        for (int i = 0; i < 5; i++)
          if (win < 0 && p[i] && en_reg[i] && pri_reg[i] && !m_hi) begin win = i; win_hi = 1; end
        for (int i = 0; i < 5; i++)
          if (win < 0 && p[i] && en_reg[i] && !pri_reg[i] && !m_hi && !m_lo) win = i;
      end
      e_req = 0; e_ack = 0;
      if (win >= 0) begin
        e_req = 1; e_ack = 1 << win; e_src = win; e_vec = 8 * win + 3;
        if (win_hi) m_hi = 1; else m_lo = 1;
      end else if (reti) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({cur, " req"}, int'(irq_req), e_req);
      chk({cur, " ack"}, int'(src_ack), e_ack);
      chk({cur, " src"}, int'(irq_src), e_src);
      chk({cur, " vec"}, int'(irq_vector), e_vec);
    end
  endtask

  task automatic clr_flags();
    ext0 = 0; tmr0 = 0; ext1 = 0; tmr1 = 0; ser_rx = 0; ser_tx = 0;
  endtask

  task automatic ret();
    insn_done = 0; reti = 1; cyc(); reti = 0; insn_done = 1;
  endtask

  initial begin
    cur = "R1"; cyc(2);
    rst_n = 1; cyc();
    chk("R1 idle", int'(irq_req), 0);
    chk("R1 vec", int'(irq_vector), 0);

    cur = "R2"; insn_done = 1; en_reg = 8'h1F;
    ext0 = 1; tmr0 = 1; ext1 = 1; tmr1 = 1; ser_tx = 1; cyc(3);
    chk("R2 master off", int'(irq_req), 0);

    cur = "R3"; en_reg = 8'h84; cyc();
    chk("R3 only ext1", int'(irq_vector), 16'h0013);
    clr_flags(); cyc(); ret(); cyc();

    cur = "R4"; en_reg = 8'h90; ser_tx = 1; cyc();
    chk("R4 tx vector", int'(irq_vector), 16'h0023);
    chk("R12 ack", int'(src_ack), 5'h10);
    clr_flags(); cyc(); ret();
    ser_rx = 1; cyc();
    chk("R4 rx", int'(irq_req), 1);
    clr_flags(); cyc(); ret();

    cur = "R6"; en_reg = 8'h9F; pri_reg = 0; tmr0 = 1; tmr1 = 1; cyc();
    chk("R6 lowest index", int'(irq_src), 1);
    chk("R5 vec", int'(irq_vector), 16'h000B);
    clr_flags(); cyc(); ret();

    cur = "R7"; pri_reg = 5'b01000; tmr0 = 1; tmr1 = 1; cyc();
    chk("R7 high wins", int'(irq_vector), 16'h001B);
    clr_flags(); cyc(); ret();

    cur = "R8"; pri_reg = 5'b01000; ext0 = 1; cyc();
    chk("R8 low taken", int'(irq_src), 0);
    ext0 = 0; ext1 = 1; cyc(2);
    chk("R8 low blocked", int'(irq_req), 0);
    tmr1 = 1; cyc();
    chk("R8 high preempts", int'(irq_src), 3);
    tmr1 = 0;
    cur = "R9"; ser_rx = 1; pri_reg = 5'b11000; cyc(2);
    chk("R9 high blocked", int'(irq_req), 0);
    ser_rx = 0; pri_reg = 5'b01000;
    cur = "R11"; ret(); cyc();
    chk("R11 low still active", int'(irq_req), 0);
    ret(); cyc(0);
    chk("R11 low freed", int'(irq_src), 3);
    cyc();
    chk("R11 ext1 taken", int'(irq_src), 2);
    clr_flags(); cyc(); ret();

    cur = "R10"; insn_done = 0; tmr0 = 1; cyc(2);
    chk("R10 no boundary", int'(irq_req), 0);
    insn_done = 1; reti = 1; cyc();
    chk("R10 reti cycle", int'(irq_req), 0);
    reti = 0; cyc();
    chk("R10 taken", int'(irq_src), 1);
    cur = "R12"; cyc();
    chk("R12 one pulse", int'(irq_req), 0);
    clr_flags(); cyc(); ret(); cyc(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (ncyc > 5000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<5000", ncyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule